// File: doc/BRIEF.md
# Two-Rail Return-to-Zero Serial Word Encoder

This block pulls 32-bit words from an upstream transmit buffer and sends each one serially, least significant bit first, as a frame of either 25 or 32 bit times. A single control input chooses the frame length. When parity is switched on, one fixed bit position inside the frame carries a computed parity bit. The sense of that bit can be set to odd or even, so a downstream receiver's parity checker can be tested with deliberately wrong frames.

Each bit leaves on two rails in return-to-zero form. A one pulses the A rail and a zero pulses the B rail, in each case for the first half of the bit time only. When both rails stay low, that bit time is a null. A bit clock with a 50% duty cycle runs without stopping and is aligned to the bit times. Consecutive frames are separated by null bit times. When no word is waiting, the rails stay at null.

The bit time is `DIV` system clocks, and `DIV` must be even. The upstream buffer presents `word_valid` and `word_data`. The block accepts the word with a one-cycle `word_take` pulse.

Top module: `rz2_tx_encoder`

## Requirements
- R1: A frame carries 32 data bit times when `len_long`=1 and 25 when `len_long`=0. A 25-bit frame sends word bits 0..24.
- R2: With parity inserted, the total number of ones in the frame is odd when `par_even`=0 and even when `par_even`=1.
- R3: Parity goes into frame bit index 7, the eighth bit sent. It is inserted only when `par_en`=1 and `par_gate_n`=0. In every other case, word bit 7 is sent unchanged.
- R4: A one is sent as `rail_a` high for the first DIV/2 cycles of its bit time. A zero is sent the same way on `rail_b`. Both rails are low in the second half of every bit time.
- R5: A null bit time has both rails low. `rail_a` and `rail_b` are never high together.
- R6: `bit_clk` is high for the first DIV/2 cycles of every bit time and low for the last DIV/2 cycles. It runs continuously, and the first bit time begins in the cycle in which reset is released.
- R7: `word_take` pulses for one cycle, in the last cycle of a bit time. It fires only when a word is valid, no frame is in progress, and at least 4 null bit times have been sent since the previous frame. The word is sampled in that cycle.
- R8: Frame bits are sent least significant first. The first bit occupies the bit time that directly follows the `word_take` cycle.
- R9: When words wait back to back, exactly 4 null bit times separate consecutive frames.
- R10: During reset, both rails and `word_take` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | Upstream holds a word to send |
| word_data | input | 32 | Word to send |
| word_take | output | 1 | Word accepted this cycle |
| len_long | input | 1 | 1: 32-bit frame, 0: 25-bit frame |
| par_en | input | 1 | Parity insertion enable |
| par_even | input | 1 | 1: even parity, 0: odd parity |
| par_gate_n | input | 1 | External parity gate, active low |
| rail_a | output | 1 | Rail carrying ones |
| rail_b | output | 1 | Rail carrying zeros |
| bit_clk | output | 1 | Free-running bit clock |

## Verification
The assertions assume that `word_data` and the three parity and length controls are stable whenever `word_take` can fire, because the frame is shaped from them in that cycle. They also assume that `DIV` is even, so the two clock halves are equal. The stimulus changes the controls only after the reference model shows the encoder idle with its null gap complete. Words come from a bench queue that is updated on the falling clock edge, so each input is steady at the sampling edge.

// File: rtl/rz2_pkg.sv
package rz2_pkg;
  localparam int WORD_W   = 32;
  localparam int SHORT_N  = 25;
  localparam int PAR_IDX  = 7;
  localparam int LEN_W    = $clog2(WORD_W + 1);

  // Number of bit times in a frame for the selected length.
  function automatic logic [LEN_W-1:0] frame_bits(input logic long_sel);
    return long_sel ? LEN_W'(WORD_W) : LEN_W'(SHORT_N);
  endfunction

  // Truncate the word to the frame length and optionally place parity at PAR_IDX.
  function automatic logic [WORD_W-1:0] shape_frame(input logic [WORD_W-1:0] w,
                                                    input logic long_sel,
                                                    input logic ins,
                                                    input logic even);
    logic [WORD_W-1:0] d;
    d = long_sel ? w : (w & ((WORD_W'(1) << SHORT_N) - WORD_W'(1)));
    if (ins) begin
      d[PAR_IDX] = 1'b0;
      d[PAR_IDX] = even ? ^d : ~^d;
    end
    return d;
  endfunction
endpackage

// File: rtl/rz2_bit_timer.sv
module rz2_bit_timer #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic first_half
);
  localparam int CW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + CW'(1);
  end

  assign tick       = (cnt == CW'(DIV - 1));
  assign first_half = (cnt < CW'(HALF));

  // R6: a new bit time always opens with the clock high
  a_r6_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> first_half);
  // R6: the clock is low in the final cycle of a bit time
  a_r6_end_low: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !first_half);
endmodule

// File: rtl/rz2_frame_seq.sv
module rz2_frame_seq
  import rz2_pkg::*;
#(
  parameter int GAP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  input  logic              long_sel,
  input  logic              ins,
  input  logic              even,
  output logic              word_take,
  output logic              sym_data,
  output logic              sym_bit
);
  localparam int GW = $clog2(GAP + 1);

  logic [WORD_W-1:0] shreg;
  logic [LEN_W-1:0]  left;
  logic [GW-1:0]     gap_cnt;
  logic              idle, gap_ok;
  logic [WORD_W-1:0] framed;

  assign idle      = (left == '0);
  assign gap_ok    = (gap_cnt >= GW'(GAP));
  assign word_take = tick && idle && gap_ok && word_valid;
  assign framed    = shape_frame(word_data, long_sel, ins, even);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      left     <= '0;
      gap_cnt  <= GW'(GAP);
      sym_data <= 1'b0;
      sym_bit  <= 1'b0;
    end else if (tick) begin
      if (!idle) begin
        sym_data <= 1'b1;
        sym_bit  <= shreg[0];
        shreg    <= shreg >> 1;
        left     <= left - LEN_W'(1);
        if (left == LEN_W'(1)) gap_cnt <= '0;
      end else if (word_take) begin
        sym_data <= 1'b1;
        sym_bit  <= framed[0];
        shreg    <= framed >> 1;
        left     <= frame_bits(long_sel) - LEN_W'(1);
      end else begin
        sym_data <= 1'b0;
        sym_bit  <= 1'b0;
        if (!gap_ok) gap_cnt <= gap_cnt + GW'(1);
      end
    end
  end

  // Observation counter for the gap assertion, driven from the emitted symbols.
  logic [GW-1:0] null_seen;
  logic          seen_word;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      null_seen <= '0;
      seen_word <= 1'b0;
    end else if (tick) begin
      if (sym_data) begin
        null_seen <= '0;
        seen_word <= 1'b1;
      end else if (null_seen < GW'(GAP)) begin
        null_seen <= null_seen + GW'(1);
      end
    end
  end

  // R8: symbols change only at bit-time boundaries
  a_r8_sym_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(sym_data) && $stable(sym_bit)));
  // R7: a word is taken only after the minimum count of null bits
  a_r7_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    word_take |-> (!sym_data && (!seen_word || null_seen >= GW'(GAP - 1))));
  // R8: the bit time after a take carries data
  a_r8_data_follows: assert property (@(posedge clk) disable iff (!rst_n)
    word_take |=> sym_data);
endmodule

// File: rtl/rz2_rail_drive.sv
module rz2_rail_drive (
  input  logic sym_data,
  input  logic sym_bit,
  input  logic first_half,
  output logic rail_a,
  output logic rail_b,
  output logic bit_clk
);
  assign rail_a  = sym_data &&  sym_bit && first_half;
  assign rail_b  = sym_data && !sym_bit && first_half;
  assign bit_clk = first_half;
endmodule

// File: rtl/rz2_tx_encoder.sv
module rz2_tx_encoder
  import rz2_pkg::*;
#(
  parameter int DIV = 8,
  parameter int GAP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              word_take,
  input  logic              len_long,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_gate_n,
  output logic              rail_a,
  output logic              rail_b,
  output logic              bit_clk
);
  logic tick, first_half, sym_data, sym_bit, ins;

  assign ins = par_en && !par_gate_n;

  rz2_bit_timer #(.DIV(DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .first_half(first_half));

  rz2_frame_seq #(.GAP(GAP)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .word_valid(word_valid), .word_data(word_data),
    .long_sel(len_long), .ins(ins), .even(par_even),
    .word_take(word_take), .sym_data(sym_data), .sym_bit(sym_bit));

  rz2_rail_drive u_drive (
    .sym_data(sym_data), .sym_bit(sym_bit), .first_half(first_half),
    .rail_a(rail_a), .rail_b(rail_b), .bit_clk(bit_clk));

  // R5: the two rails are never high together
  a_r5_rails_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rail_a && rail_b));
  // R4: pulses sit only in the clock-high half
  a_r4_rz_half: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_a || rail_b) |-> bit_clk);
  // R7: a take is a single-cycle pulse
  a_r7_take_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    word_take |=> !word_take);
endmodule

// File: tb/tb_rz2_tx_encoder.sv
module tb_rz2_tx_encoder;
  localparam int DIV = 8;
  localparam int GAP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic word_valid = 1'b0, len_long = 1'b1, par_en = 1'b0, par_even = 1'b0, par_gate_n = 1'b1;
  logic [31:0] word_data = '0;
  logic word_take, rail_a, rail_b, bit_clk;

  rz2_tx_encoder #(.DIV(DIV), .GAP(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
    .word_take(word_take), .len_long(len_long), .par_en(par_en),
    .par_even(par_even), .par_gate_n(par_gate_n),
    .rail_a(rail_a), .rail_b(rail_b), .bit_clk(bit_clk));

  always #4ns clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] wq[$];
  // expected frames, recorded when the model accepts a word
  logic [31:0] ef[$], ew[$];
  int el[$];
  bit eins[$], eeven[$];

  // reference model state
  int m_ph = 0, m_left = 0, m_nulls = GAP;
  bit m_sd = 0, m_sb = 0;
  logic [31:0] m_sh = '0;

  // receiver-side decoder
  logic [31:0] cur = '0;
  int cur_n = 0, null_run = 0, frames = 0;
  bit skip_gap = 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  function automatic logic [31:0] ref_frame(input logic [31:0] w, input bit l, input bit ins, input bit ev);
    logic [31:0] r = '0;
    int n = l ? 32 : 25;
    int ones = 0;
    for (int i = 0; i < n; i++) begin
      r[i] = w[i];
      if (i != 7 && w[i]) ones++;
    end
    if (ins) r[7] = ev ? ((ones % 2) == 1) : ((ones % 2) == 0);
    return r;
  endfunction

  task automatic drive_inputs();
    word_valid = (wq.size() != 0);
    word_data  = (wq.size() != 0) ? wq[0] : 32'h0;
  endtask

  task automatic decode();
    bit ins_now;
    int ones;
    if (rail_a || rail_b) begin
      if (cur_n == 0 && frames > 0) begin
        chk(null_run >= GAP, "R7 null gap", null_run, GAP);
        if (!skip_gap) chk(null_run == GAP, "R9 back-to-back gap", null_run, GAP);
      end
      if (cur_n == 0) skip_gap = 0;
      if (cur_n < 32) cur[cur_n] = rail_a;
      cur_n++;
    end else begin
      if (cur_n > 0) begin
        if (ef.size() == 0) begin
          chk(0, "R8 unexpected frame", cur, 0);
        end else begin
          ins_now = eins[0];
          chk(cur_n == el[0], "R1 frame length", cur_n, el[0]);
          chk(cur == ef[0], "R8 frame bits", cur, ef[0]);
          if (ins_now) begin
            ones = $countones(cur);
            chk((ones % 2) == (eeven[0] ? 0 : 1), "R2 parity sense", ones, eeven[0]);
          end else begin
            chk(cur[7] == ew[0][7], "R3 bit 7 passthrough", cur[7], ew[0][7]);
          end
          void'(ef.pop_front()); void'(ew.pop_front()); void'(el.pop_front());
          void'(eins.pop_front()); void'(eeven.pop_front());
        end
        frames++;
        cur = '0; cur_n = 0; null_run = 0;
      end
      null_run++;
    end
  endtask

  // compare the sampled outputs with the model, then advance both one clock
  task automatic step();
    bit exp_take, half, ins_now;
    logic [31:0] fr;
    half = (m_ph < DIV / 2);
    exp_take = (m_ph == DIV - 1) && (m_left == 0) && (m_nulls >= GAP) && (wq.size() != 0);
    chk(bit_clk == half, "R6 bit clock", bit_clk, half);
    chk(rail_a == (m_sd && m_sb && half) && rail_b == (m_sd && !m_sb && half),
        "R4 rail encoding", {rail_a, rail_b}, {m_sd && m_sb && half, m_sd && !m_sb && half});
    chk(!(rail_a && rail_b), "R5 rails exclusive", {rail_a, rail_b}, 0);
    chk(word_take == exp_take, "R7 take timing", word_take, exp_take);
    if (m_ph == 0) decode();
    if (m_ph == DIV - 1) begin
      if (m_left != 0) begin
        m_sd = 1; m_sb = m_sh[0]; m_sh = m_sh >> 1; m_left--;
        if (m_left == 0) m_nulls = 0;
      end else if (exp_take) begin
        ins_now = par_en && !par_gate_n;
        fr = ref_frame(wq[0], len_long, ins_now, par_even);
        ef.push_back(fr); ew.push_back(wq[0]); el.push_back(len_long ? 32 : 25);
        eins.push_back(ins_now); eeven.push_back(par_even);
        void'(wq.pop_front());
        m_sd = 1; m_sb = fr[0]; m_sh = fr >> 1; m_left = (len_long ? 32 : 25) - 1;
      end else begin
        m_sd = 0; m_sb = 0;
        if (m_nulls < GAP) m_nulls++;
      end
    end
    m_ph = (m_ph + 1) % DIV;
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    @(negedge clk);
    drive_inputs();
  endtask

  task automatic scenario(input bit l, input bit pe, input bit pg_n, input bit ev);
    len_long = l; par_en = pe; par_gate_n = pg_n; par_even = ev;
    skip_gap = 1;
    drive_inputs();
    while (wq.size() != 0 || m_left != 0 || m_nulls < GAP || cur_n != 0) step();
    repeat (2 * DIV) step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 / R6: reset state
    chk(!rail_a && !rail_b, "R10 rails low in reset", {rail_a, rail_b}, 0);
    chk(!word_take, "R10 no take in reset", word_take, 0);
    chk(bit_clk, "R6 clock high in reset", bit_clk, 1);
    rst_n = 1'b1;
    // idle: rails stay at null
    repeat (5 * DIV) step();
    // R1 long frames, no parity, back to back
    wq.push_back(32'hA5C3_0F81); wq.push_back(32'hFFFF_FFFF); wq.push_back(32'h0000_0001);
    scenario(1, 0, 1, 0);
    // R1 short frames with odd parity (R2, R3)
    wq.push_back(32'h0000_0000); wq.push_back(32'hFFFF_FFFF); wq.push_back(32'h1234_5678);
    scenario(0, 1, 0, 0);
    // R2 even parity, long frames
    wq.push_back(32'h8000_0080); wq.push_back(32'h7F3E_1D2C); wq.push_back(32'h0000_0000);
    scenario(1, 1, 0, 1);
    // R3 gate pin blocks insertion
    wq.push_back(32'h0000_0080); wq.push_back(32'hFFFF_FF7F);
    scenario(1, 1, 1, 0);
    // R3 parity disabled while gate allows
    wq.push_back(32'hDEAD_BEEF);
    scenario(0, 0, 0, 1);
    // R7 single word after a long idle gap
    repeat (20 * DIV) step();
    wq.push_back(32'h0F0F_F0F0);
    scenario(0, 1, 0, 1);
    chk(ef.size() == 0, "R8 all frames received", ef.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3ms;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule